// File: doc/BRIEF.md
# Vector FP Scalar Operand Unboxer

This block turns a scalar held in a 64-bit floating-point register into an element for a vector operation at a chosen element width of 16, 32 or 64 bits. When the element is narrower than the register, the register must be NaN-boxed: every bit above the element must be one. A correctly boxed value gives its low bits unchanged, even if they encode a signaling or non-canonical NaN. A badly boxed value is replaced by the canonical quiet NaN of the element format. A width the register cannot hold, or the 8-bit code that has no FP format, is flagged as reserved and gives a zero element.

Besides the element, the block fills a 128-bit lane with copies of the element at the chosen width, ready for splat, merge or slide-in use. A separate status bit reports when the canonical NaN was substituted. Requests enter through a valid/ready pair and results leave through a valid/ready pair, with one output register between them. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value.

Top module: `fp_scalar_unbox`

## Requirements
- R1: The width code `in_sew` maps 2'b01 to 16 bits and 2'b10 to 32 bits. When a 16- or 32-bit element is requested and every register bit above the element is one, `out_elem` equals the low element bits unchanged. This holds for any NaN payload, including signaling NaNs such as 32'hff80_ffff.
- R2: When any register bit above the element is zero, `out_elem` is the canonical NaN: 16'h7e00 for 16 bits and 32'h7fc0_0000 for 32 bits. A zero at the lowest bit above the element is enough to fail the check.
- R3: `out_box_fail` is 1 exactly when the canonical NaN was substituted, and 0 for boxed values, for 64-bit elements and for reserved codes.
- R4: Code 2'b11 selects 64 bits. The whole register passes through unchanged, with no box check.
- R5: Code 2'b00 asserts `out_reserved`, and both `out_elem` and `out_lane` are zero.
- R6: `out_lane` holds 128/SEW copies of the element. Element 0 is in bits [SEW-1:0], and each following copy sits SEW bits higher.
- R7: A request accepted at a clock edge (`in_valid` and `in_ready` both high) raises `out_valid` at that same edge, so the result is visible in the following cycle. An active-low synchronous reset clears `out_valid`.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and all data outputs stay stable. `in_ready` is high when `out_valid` is low or `out_ready` is high.
- R9: `out_elem` is zero-extended above the element width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request is present |
| in_ready | output | 1 | The block can accept a request this cycle |
| in_reg | input | 64 | Scalar FP register contents |
| in_sew | input | 2 | Element width code (00 reserved, 01=16, 10=32, 11=64) |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | The consumer accepts the result |
| out_elem | output | 64 | Element value, zero-extended |
| out_lane | output | 128 | Element replicated across the lane |
| out_reserved | output | 1 | The width code is reserved |
| out_box_fail | output | 1 | The canonical NaN replaced an improperly boxed value |

## Verification
Every result is registered once. A request accepted at clock edge N appears on the outputs after that edge, and it leaves at the first later edge where `out_ready` is high. The bench drives inputs on the falling edge. A scoreboard queue receives each expected result at the moment of acceptance. The monitor compares the front of the queue only on falling edges where `out_valid` and `out_ready` are both high, so each result is checked once, in order, however long it was stalled. The monitor also checks that `out_valid` is high one falling edge after each acceptance, and that outputs held under back-pressure stay unchanged into the next cycle.

// File: rtl/fpub_pkg.sv
package fpub_pkg;

  typedef enum logic [1:0] {
    SEW_E8  = 2'b00,
    SEW_E16 = 2'b01,
    SEW_E32 = 2'b10,
    SEW_E64 = 2'b11
  } sew_e;

  localparam int unsigned NUM_FP_W = 3;

  // Exponent field width of the IEEE format with the given total width.
  function automatic int unsigned exp_bits(input int unsigned w);
    case (w)
      16:      return 5;
      32:      return 8;
      default: return 11;
    endcase
  endfunction

  // Quiet NaN with clear sign: exponent all ones and top mantissa bit set.
  function automatic logic [63:0] canon_nan(input int unsigned w);
    int unsigned e;
    int unsigned m;
    e = exp_bits(w);
    m = w - 1 - e;
    return ((64'd1 << (e + 1)) - 64'd1) << (m - 1);
  endfunction

endpackage

// File: rtl/fpub_sew_decode.sv
module fpub_sew_decode
  import fpub_pkg::*;
#(
  parameter int unsigned FLEN = 64
) (
  input  sew_e                      code,
  output logic                      reserved,
  output logic [NUM_FP_W-1:0]       sel
);

  int unsigned width;

  always_comb begin
    width    = 8 << code;
    reserved = (code == SEW_E8) || (width > FLEN);
    for (int k = 0; k < NUM_FP_W; k++) begin
      sel[k] = !reserved && (code == sew_e'(k + 1));
    end
  end

endmodule

// File: rtl/fpub_box_check.sv
module fpub_box_check
  import fpub_pkg::*;
#(
  parameter int unsigned FLEN = 64,
  parameter int unsigned W    = 32
) (
  input  logic [FLEN-1:0] src,
  output logic [FLEN-1:0] elem,
  output logic            fail
);

  localparam logic [63:0] CANON = canon_nan(W);

  generate
    if (W > FLEN) begin : g_too_wide
      assign elem = '0;
      assign fail = 1'b0;
    end else if (W == FLEN) begin : g_full
      assign elem = src;
      assign fail = 1'b0;
    end else begin : g_boxed
      logic boxed;
      assign boxed = &src[FLEN-1:W];
      assign fail  = !boxed;
      assign elem  = boxed ? {{(FLEN-W){1'b0}}, src[W-1:0]}
                           : {{(FLEN-W){1'b0}}, CANON[W-1:0]};
    end
  endgenerate

endmodule

// File: rtl/fpub_lane_rep.sv
module fpub_lane_rep
  import fpub_pkg::*;
#(
  parameter int unsigned FLEN   = 64,
  parameter int unsigned LANE_W = 128
) (
  input  logic [FLEN-1:0]     elem,
  input  logic [NUM_FP_W-1:0] sel,
  output logic [LANE_W-1:0]   lane
);

  localparam int unsigned CHUNK   = 16;
  localparam int unsigned NCHUNK  = LANE_W / CHUNK;

  logic [63:0] e64;
  assign e64 = 64'(elem);

  generate
    for (genvar j = 0; j < NCHUNK; j++) begin : g_chunk
      always_comb begin
        lane[j*CHUNK +: CHUNK] = '0;
        if (sel[0]) lane[j*CHUNK +: CHUNK] = e64[15:0];
        if (sel[1]) lane[j*CHUNK +: CHUNK] = e64[(j % 2) * CHUNK +: CHUNK];
        if (sel[2]) lane[j*CHUNK +: CHUNK] = e64[(j % 4) * CHUNK +: CHUNK];
      end
    end
  endgenerate

endmodule

// File: rtl/fp_scalar_unbox.sv
module fp_scalar_unbox
  import fpub_pkg::*;
#(
  parameter int unsigned FLEN   = 64,
  parameter int unsigned LANE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLEN-1:0]   in_reg,
  input  logic [1:0]        in_sew,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLEN-1:0]   out_elem,
  output logic [LANE_W-1:0] out_lane,
  output logic              out_reserved,
  output logic              out_box_fail
);

  logic                rsv_c;
  logic [NUM_FP_W-1:0] sel_c;
  logic [FLEN-1:0]     elem_k [NUM_FP_W];
  logic [NUM_FP_W-1:0] fail_k;
  logic [FLEN-1:0]     elem_c;
  logic                fail_c;
  logic [LANE_W-1:0]   lane_c;
  logic                load;

  fpub_sew_decode #(.FLEN(FLEN)) u_dec (
    .code     (sew_e'(in_sew)),
    .reserved (rsv_c),
    .sel      (sel_c)
  );

  generate
    for (genvar k = 0; k < NUM_FP_W; k++) begin : g_width
      fpub_box_check #(.FLEN(FLEN), .W(16 << k)) u_box (
        .src  (in_reg),
        .elem (elem_k[k]),
        .fail (fail_k[k])
      );
    end
  endgenerate

  always_comb begin
    elem_c = '0;
    fail_c = 1'b0;
    for (int k = 0; k < NUM_FP_W; k++) begin
      if (sel_c[k]) begin
        elem_c = elem_k[k];
        fail_c = fail_k[k];
      end
    end
  end

  fpub_lane_rep #(.FLEN(FLEN), .LANE_W(LANE_W)) u_rep (
    .elem (elem_c),
    .sel  (sel_c),
    .lane (lane_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      out_elem     <= elem_c;
      out_lane     <= lane_c;
      out_reserved <= rsv_c;
      out_box_fail <= fail_c;
    end
  end

endmodule

// File: rtl/fpub_checker.sv
module fpub_checker #(
  parameter int unsigned FLEN   = 64,
  parameter int unsigned LANE_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [FLEN-1:0]   out_elem,
  input logic [LANE_W-1:0] out_lane,
  input logic              out_reserved,
  input logic              out_box_fail
);

  AST_RESET_CLEARS_VALID: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R7

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R7

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_elem) && $stable(out_lane)
      && $stable(out_box_fail) && $stable(out_reserved)); // R8

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_reserved |-> out_elem == '0 && out_lane == '0 && !out_box_fail); // R5

  AST_FAIL_IS_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_box_fail |->
      (64'(out_elem) == 64'h7e00 || 64'(out_elem) == 64'h7fc0_0000)); // R2

  AST_LANE_ELEM0: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_reserved |-> out_lane[15:0] == out_elem[15:0]); // R6

endmodule

bind fp_scalar_unbox fpub_checker #(.FLEN(FLEN), .LANE_W(LANE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_elem     (out_elem),
  .out_lane     (out_lane),
  .out_reserved (out_reserved),
  .out_box_fail (out_box_fail)
);

// File: tb/fp_scalar_unbox_test.sv
`timescale 1ns/1ps
module fp_scalar_unbox_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [63:0]  in_reg = '0;
  logic [1:0]   in_sew = 2'b00;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [63:0]  out_elem;
  logic [127:0] out_lane;
  logic         out_reserved;
  logic         out_box_fail;

  int errors = 0;
  int checks = 0;
  int rdy_mode = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic [63:0]  e;
    logic [127:0] l;
    logic         r;
    logic         f;
    string        tag;
  } exp_t;
  exp_t q[$];

  fp_scalar_unbox uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_reg(in_reg), .in_sew(in_sew), .out_valid(out_valid), .out_ready(out_ready),
    .out_elem(out_elem), .out_lane(out_lane), .out_reserved(out_reserved),
    .out_box_fail(out_box_fail)
  );

  always #10 clk = ~clk;

  function automatic exp_t model(input logic [63:0] r, input logic [1:0] c, input string tag);
    exp_t x;
    int w;
    logic [63:0] canon;
    x.tag = tag; x.e = '0; x.l = '0; x.r = 1'b0; x.f = 1'b0;
    if (c == 2'b00) begin
      x.r = 1'b1;
      return x;
    end
    w = 8 << c;
    canon = (w == 16) ? 64'h7e00 : (w == 32) ? 64'h7fc0_0000 : 64'h7ff8_0000_0000_0000;
    if (w == 64) x.e = r;
    else if ((r >> w) == ({64{1'b1}} >> w)) x.e = r & ((64'd1 << w) - 1);
    else begin x.e = canon; x.f = 1'b1; end
    for (int i = 0; i < 128 / w; i++)
      for (int b = 0; b < w; b++) x.l[i*w + b] = x.e[b];
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic send(input logic [63:0] r, input logic [1:0] c, input string tag);
    @(negedge clk);
    in_reg = r; in_sew = c; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    q.push_back(model(r, c, tag));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // out_ready pattern
  initial forever begin
    @(negedge clk);
    cyc++;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  // monitor / scoreboard
  initial begin
    bit acc_prev = 0;
    bit hold_prev = 0;
    logic [63:0]  h_e;
    logic [127:0] h_l;
    forever begin
      @(negedge clk); #2;
      if (!rst_n) begin acc_prev = 0; hold_prev = 0; continue; end
      if (acc_prev) check(out_valid === 1'b1, "R7", "valid after accept", out_valid, 1);
      if (hold_prev) begin
        check(out_valid === 1'b1 && out_elem === h_e, "R8", "stall hold elem", out_elem, h_e);
        check(out_lane === h_l, "R8", "stall hold lane", out_lane, h_l);
      end
      if (out_valid && out_ready) begin
        if (q.size() == 0) check(0, "R7", "unexpected result", out_elem, 0);
        else begin
          exp_t x;
          x = q.pop_front();
          check(out_elem === x.e, x.tag, "elem", out_elem, x.e);
          check(out_lane === x.l, "R6", {"lane ", x.tag}, out_lane, x.l);
          check(out_reserved === x.r, "R5", {"reserved ", x.tag}, out_reserved, x.r);
          check(out_box_fail === x.f, "R3", {"box_fail ", x.tag}, out_box_fail, x.f);
        end
      end
      acc_prev  = in_valid && in_ready;
      hold_prev = out_valid && !out_ready;
      h_e = out_elem; h_l = out_lane;
    end
  end

  initial begin
    #(20 * 50000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R7", "reset valid", out_valid, 0);
    check(in_ready === 1'b1, "R8", "reset in_ready", in_ready, 1);
    @(negedge clk); rst_n = 1'b1;

    send(64'hffff_ffff_3f80_0000, 2'b10, "R1 boxed single");
    send(64'hffff_ffff_ff80_ffff, 2'b10, "R1 boxed signaling kept");
    send(64'hffff_ff0f_ffff_ffff, 2'b10, "R2 unboxed single");
    send(64'hffff_fffe_1234_5678, 2'b10, "R2 bit32 zero");
    send(64'hffff_ffff_ffff_7c01, 2'b01, "R1 boxed half snan");
    send(64'h7fff_ffff_ffff_1234, 2'b01, "R2 sign bit zero half");
    send(64'hffff_ffff_fffe_abcd, 2'b01, "R2 bit16 zero");
    send(64'h0123_4567_89ab_cdef, 2'b11, "R4 double passthrough");
    send(64'h7ff4_0000_0000_0001, 2'b11, "R4 double snan kept");
    send(64'h0000_0000_0000_0000, 2'b00, "R5 reserved zero in");
    send(64'hffff_ffff_ffff_ffff, 2'b00, "R5 reserved ones in");
    send(64'hffff_ffff_0000_0001, 2'b10, "R9 zero extension");

    rdy_mode = 1;
    send(64'hffff_ffff_0000_abcd, 2'b10, "R8 stalled single");
    send(64'hffff_ffff_ffff_1111, 2'b01, "R8 stalled half");
    send(64'h1111_2222_3333_4444, 2'b11, "R8 stalled double");
    send(64'h8000_ffff_ffff_0000, 2'b01, "R2 stalled unboxed");
    send(64'h5555_5555_5555_5555, 2'b00, "R5 stalled reserved");
    while (q.size() != 0) @(negedge clk);

    // back-pressure hold then reset clears valid
    rdy_mode = 2;
    send(64'hffff_ffff_4049_0fdb, 2'b10, "R8 held");
    repeat (3) @(negedge clk);
    #3;
    check(out_valid === 1'b1, "R8", "held valid", out_valid, 1);
    check(in_ready === 1'b0, "R8", "in_ready low while full", in_ready, 0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); #3;
    check(out_valid === 1'b0, "R7", "reset clears valid", out_valid, 0);
    q.delete();
    done = 1;
    finish_run();
  end

endmodule